// File: doc/BRIEF.md
# SDRAM Command Issue Stage with Shared-Pin Handshake

This block sits between an SDRAM controller's internal engine and the memory pins. The engine hands over one command at a time: an operation code, a chip-select index, a bank, a row or column address and, for writes, the data word. The block holds the command and raises a request for each pin group the command needs. It then waits for the matching grant from an external pin arbiter and drives the command onto the control, address and data pins for exactly one cycle.

The pins fall into three groups. Clock enable, byte mask and the memory clock never wait on any handshake. The strobes and chip selects form the control group, which every command needs. The address and data lines form the bus group, which only addressed commands use. A command that carries an address waits only on the bus grant and pays no attention to the control grant. The arbiter raises both grants together for such a command. Refresh, self-refresh and no-operation wait on the control grant alone. While a command is waiting, the control pins show a deselect and the data bus is not driven. All handshake signals are active high and are timed from the system clock.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: `cke_o` and `dqm_o` take the values of `cke_in` and `dqm_in` at every rising clock edge, whatever the state of requests and grants. `mem_clk_o` follows `clk`.
- R2: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from that edge until the edge on which the command is issued, and the held command does not change while it waits.
- R3: `ctl_req` is high from the cycle after acceptance through the cycle in which the command is on the pins. `bus_req` is high over the same span only for addressed commands. It is never high for refresh, self-refresh, no-operation or undefined codes.
- R4: An addressed command (activate, read, read+autoprecharge, write, write+autoprecharge, precharge, precharge all, mode register set) is issued at the first rising edge with `bus_gnt` high, whatever `ctl_gnt` is. It appears on the pins in the following cycle.
- R5: A command without an address (refresh, self-refresh, no-operation) is issued at the first rising edge with `ctl_gnt` high, whatever `bus_gnt` is.
- R6: In every cycle in which no command is being driven, including while a command waits for its grant, `cs_n` is all ones, `ras_n`/`cas_n`/`we_n` are high and `dq_oe` is low.
- R7: Operation codes and their strobe levels {ras_n,cas_n,we_n}: 0 no-op 111, 1 activate 011, 2 read 101, 3 read+autoprecharge 101, 4 write 100, 5 write+autoprecharge 100, 6 precharge 010, 7 precharge all 010, 8 refresh 001, 9 self-refresh 001, 10 mode register set 000.
- R8: In the issue cycle, `addr_o[14:13]` is the bank and `addr_o[12:0]` is the supplied address, except as follows. Bit 10 is forced to 1 for read+autoprecharge, write+autoprecharge and precharge all. It is forced to 0 for read, write and precharge. `addr_o` is all zeros for commands without an address and in every cycle without an issued addressed command.
- R9: In the issue cycle, exactly the chip select numbered by `cmd_cs` is low in `cs_n`.
- R10: `dq_oe` is high and `dq_o` equals the write data only in the issue cycle of a write or write+autoprecharge. In all other cycles `dq_oe` is low and `dq_o` is zero.
- R11: Requests fall in the cycle after the issue cycle unless a new command was accepted at the end of the issue cycle. In that case `ctl_req` stays high without a gap.
- R12: Codes 11 to 15 are issued as a no-operation, with the control grant and no bus request.
- R13: Reset is synchronous and active high. During reset and after it, `cmd_ready` is 1, both requests are 0, `cs_n` is all ones, the strobes are high, `dq_oe` is 0, `addr_o` is 0, `cke_o` is 0 and `dqm_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Engine presents a command |
| cmd_op | input | 4 | Operation code (R7) |
| cmd_cs | input | 2 | Chip-select index |
| cmd_bank | input | 2 | Bank number |
| cmd_addr | input | 13 | Row or column address |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Block can take a command |
| cke_in | input | 4 | Clock-enable levels from the engine |
| dqm_in | input | 4 | Byte-mask levels from the engine |
| ctl_req | output | 1 | Control-group pin request |
| ctl_gnt | input | 1 | Control-group grant |
| bus_req | output | 1 | Address/data-group pin request |
| bus_gnt | input | 1 | Address/data-group grant |
| mem_clk_o | output | 1 | Memory clock |
| cke_o | output | 4 | Clock enable pins |
| dqm_o | output | 4 | Byte mask pins |
| cs_n | output | 4 | Chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr_o | output | 15 | Bank and address pins |
| dq_o | output | 32 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |

## Verification
Assertions check several properties on every cycle. Any issued command must follow a sample of the right grant: the bus grant for addressed commands and the control grant for the rest. A waiting command must stay unchanged. Driven chip selects, addresses and data must sit under the matching request. Data must be enabled only with write strobes, and at most one chip select may be low at a time. Only the bench can show the rest. That covers the strobe and address values of each operation code and the forcing of bit 10. It also shows that a withheld grant really stalls a command while the other grant is high, that requests drop after the issue cycle or carry on unbroken into a back-to-back command, and the reset levels.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ACT  = 4'd1,
    OP_RD   = 4'd2,
    OP_RDA  = 4'd3,
    OP_WR   = 4'd4,
    OP_WRA  = 4'd5,
    OP_PRE  = 4'd6,
    OP_PALL = 4'd7,
    OP_REF  = 4'd8,
    OP_SREF = 4'd9,
    OP_MRS  = 4'd10
  } op_e;

  // How bit 10 of the address pins is formed.
  typedef enum logic [1:0] {
    AP_PASS = 2'd0,
    AP_SET  = 2'd1,
    AP_CLR  = 2'd2,
    AP_ZERO = 2'd3
  } ap_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic uses_bus;
    logic is_write;
    ap_e  ap;
  } cmd_attr_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic [3:0] op_i,
  output cmd_attr_t  attr_o
);

  always_comb begin
    attr_o = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
               uses_bus: 1'b0, is_write: 1'b0, ap: AP_ZERO};
    case (op_i)
      OP_ACT:  attr_o = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AP_PASS};
      OP_RD:   attr_o = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, AP_CLR};
      OP_RDA:  attr_o = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, AP_SET};
      OP_WR:   attr_o = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, AP_CLR};
      OP_WRA:  attr_o = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, AP_SET};
      OP_PRE:  attr_o = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AP_CLR};
      OP_PALL: attr_o = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AP_SET};
      OP_REF:  attr_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AP_ZERO};
      OP_SREF: attr_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AP_ZERO};
      OP_MRS:  attr_o = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AP_PASS};
      default: ; // no-op and undefined codes (R12)
    endcase
  end

endmodule

// File: rtl/sdram_grant_ctrl.sv
module sdram_grant_ctrl #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 cmd_ready_o,
  output logic [PAYLOAD_W-1:0] pend_payload_o,
  input  logic                 pend_bus_i,
  input  logic                 ctl_gnt_i,
  input  logic                 bus_gnt_i,
  output logic                 fire_o,
  output logic                 ctl_req_o,
  output logic                 bus_req_o
);

  logic                 pend_q;
  logic                 issue_q;
  logic                 issue_bus_q;
  logic [PAYLOAD_W-1:0] payload_q;
  logic                 fire;

  // Addressed commands look only at the bus grant; the rest at the control grant.
  assign fire = pend_q && (pend_bus_i ? bus_gnt_i : ctl_gnt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      issue_q     <= 1'b0;
      issue_bus_q <= 1'b0;
      payload_q   <= '0;
    end else begin
      issue_q     <= fire;
      issue_bus_q <= fire && pend_bus_i;
      if (fire) begin
        pend_q <= 1'b0;
      end else if (!pend_q && cmd_valid_i) begin
        pend_q    <= 1'b1;
        payload_q <= payload_i;
      end
    end
  end

  assign cmd_ready_o    = !pend_q;
  assign pend_payload_o = payload_q;
  assign fire_o         = fire;
  assign ctl_req_o      = pend_q || issue_q;
  assign bus_req_o      = (pend_q && pend_bus_i) || (issue_q && issue_bus_q);

  assert_hold_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !fire) |=> (pend_q && $stable(payload_q)));

  assert_bus_issue_on_gnt_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_q && issue_bus_q) |-> $past(bus_gnt_i));

  assert_ctl_issue_on_gnt_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_q && !issue_bus_q) |-> $past(ctl_gnt_i));

endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_cmd_pkg::*;
#(
  parameter int CS_N   = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter int CKE_W  = 4,
  parameter int AP_BIT = 10,
  localparam int CS_IDX_W = (CS_N > 1) ? $clog2(CS_N) : 1,
  localparam int ROW_W    = ADDR_W - BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire_i,
  input  cmd_attr_t           attr_i,
  input  logic [CS_IDX_W-1:0] cs_idx_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [CKE_W-1:0]    cke_i,
  input  logic [MASK_W-1:0]   dqm_i,
  output logic [CKE_W-1:0]    cke_o,
  output logic [MASK_W-1:0]   dqm_o,
  output logic [CS_N-1:0]     cs_n_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe_o
);

  logic [CS_N-1:0]   cs_sel;
  logic [ADDR_W-1:0] addr_fmt;

  for (genvar g = 0; g < CS_N; g++) begin : g_cs_sel
    assign cs_sel[g] = (cs_idx_i == CS_IDX_W'(g));
  end

  always_comb begin
    addr_fmt = {bank_i, addr_i};
    case (attr_i.ap)
      AP_SET:  addr_fmt[AP_BIT] = 1'b1;
      AP_CLR:  addr_fmt[AP_BIT] = 1'b0;
      AP_ZERO: addr_fmt = '0;
      default: ;
    endcase
  end

  // Group one: straight through a register, no handshake involved.
  always_ff @(posedge clk) begin
    if (rst) begin
      cke_o <= '0;
      dqm_o <= '1;
    end else begin
      cke_o <= cke_i;
      dqm_o <= dqm_i;
    end
  end

  // Groups two and three: command for one cycle on issue, idle levels otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o  <= '1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      cs_n_o  <= fire_i ? ~cs_sel : '1;
      ras_n_o <= fire_i ? attr_i.ras_n : 1'b1;
      cas_n_o <= fire_i ? attr_i.cas_n : 1'b1;
      we_n_o  <= fire_i ? attr_i.we_n  : 1'b1;
      addr_o  <= fire_i ? addr_fmt : '0;
      dq_oe_o <= fire_i && attr_i.is_write;
      dq_o    <= (fire_i && attr_i.is_write) ? wdata_i : '0;
    end
  end

  assert_oe_with_write_strobes_R10: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (!we_n_o && !cas_n_o && ras_n_o));

  assert_single_chip_select_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n_o) <= 1);

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int CS_N   = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter int CKE_W  = 4,
  parameter int AP_BIT = 10
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      cmd_valid,
  input  logic [3:0]                                cmd_op,
  input  logic [((CS_N > 1) ? $clog2(CS_N) : 1)-1:0] cmd_cs,
  input  logic [BANK_W-1:0]                         cmd_bank,
  input  logic [ADDR_W-BANK_W-1:0]                  cmd_addr,
  input  logic [DATA_W-1:0]                         cmd_wdata,
  output logic                                      cmd_ready,
  input  logic [CKE_W-1:0]                          cke_in,
  input  logic [MASK_W-1:0]                         dqm_in,
  output logic                                      ctl_req,
  input  logic                                      ctl_gnt,
  output logic                                      bus_req,
  input  logic                                      bus_gnt,
  output logic                                      mem_clk_o,
  output logic [CKE_W-1:0]                          cke_o,
  output logic [MASK_W-1:0]                         dqm_o,
  output logic [CS_N-1:0]                           cs_n,
  output logic                                      ras_n,
  output logic                                      cas_n,
  output logic                                      we_n,
  output logic [ADDR_W-1:0]                         addr_o,
  output logic [DATA_W-1:0]                         dq_o,
  output logic                                      dq_oe
);

  localparam int CS_IDX_W  = (CS_N > 1) ? $clog2(CS_N) : 1;
  localparam int ROW_W     = ADDR_W - BANK_W;
  localparam int PAYLOAD_W = 4 + CS_IDX_W + BANK_W + ROW_W + DATA_W;

  logic [PAYLOAD_W-1:0] pend_payload;
  logic [3:0]           pend_op;
  logic [CS_IDX_W-1:0]  pend_cs;
  logic [BANK_W-1:0]    pend_bank;
  logic [ROW_W-1:0]     pend_addr;
  logic [DATA_W-1:0]    pend_wdata;
  cmd_attr_t            pend_attr;
  logic                 fire;

  assign {pend_op, pend_cs, pend_bank, pend_addr, pend_wdata} = pend_payload;
  assign mem_clk_o = clk;

  sdram_cmd_decode u_decode (
    .op_i   (pend_op),
    .attr_o (pend_attr)
  );

  sdram_grant_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_grant (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_i    (cmd_valid),
    .payload_i      ({cmd_op, cmd_cs, cmd_bank, cmd_addr, cmd_wdata}),
    .cmd_ready_o    (cmd_ready),
    .pend_payload_o (pend_payload),
    .pend_bus_i     (pend_attr.uses_bus),
    .ctl_gnt_i      (ctl_gnt),
    .bus_gnt_i      (bus_gnt),
    .fire_o         (fire),
    .ctl_req_o      (ctl_req),
    .bus_req_o      (bus_req)
  );

  sdram_pin_drive #(
    .CS_N(CS_N), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_W(MASK_W), .CKE_W(CKE_W), .AP_BIT(AP_BIT)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (fire),
    .attr_i   (pend_attr),
    .cs_idx_i (pend_cs),
    .bank_i   (pend_bank),
    .addr_i   (pend_addr),
    .wdata_i  (pend_wdata),
    .cke_i    (cke_in),
    .dqm_i    (dqm_in),
    .cke_o    (cke_o),
    .dqm_o    (dqm_o),
    .cs_n_o   (cs_n),
    .ras_n_o  (ras_n),
    .cas_n_o  (cas_n),
    .we_n_o   (we_n),
    .addr_o   (addr_o),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe)
  );

  assert_cs_under_ctl_req_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> ctl_req);

  assert_data_under_bus_req_R10: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> bus_req);

  assert_addr_under_bus_req_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_o != '0) |-> bus_req);

  assert_bus_implies_ctl_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ctl_req);

endmodule

// File: tb/tb_sdram_cmd_issuer.sv
`timescale 1ns/1ps
module tb_sdram_cmd_issuer;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [1:0]  cmd_cs;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic        cmd_ready;
  logic [3:0]  cke_in, dqm_in;
  logic        ctl_req, ctl_gnt, bus_req, bus_gnt;
  logic        mem_clk_o;
  logic [3:0]  cke_o, dqm_o, cs_n;
  logic        ras_n, cas_n, we_n;
  logic [14:0] addr_o;
  logic [31:0] dq_o;
  logic        dq_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk; // 200 MHz

  sdram_cmd_issuer dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cs(cmd_cs),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .cke_in(cke_in), .dqm_in(dqm_in),
    .ctl_req(ctl_req), .ctl_gnt(ctl_gnt), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_clk_o(mem_clk_o), .cke_o(cke_o), .dqm_o(dqm_o), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_o(addr_o),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // Entry: [27:24] op, [23:22] cs, [21:20] bank, [19:7] addr,
  //        [6:4] ras/cas/we, [3] bus, [2] write, [1:0] bit-10 rule
  //        (0 pass, 1 force high, 2 force low, 3 all zero)
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {4'd0,  2'd1, 2'd3, 13'h1234, 3'b111, 1'b0, 1'b0, 2'd3},
    {4'd1,  2'd0, 2'd2, 13'h1555, 3'b011, 1'b1, 1'b0, 2'd0},
    {4'd2,  2'd2, 2'd1, 13'h0400, 3'b101, 1'b1, 1'b0, 2'd2},
    {4'd3,  2'd3, 2'd3, 13'h0012, 3'b101, 1'b1, 1'b0, 2'd1},
    {4'd4,  2'd1, 2'd0, 13'h1FFF, 3'b100, 1'b1, 1'b1, 2'd2},
    {4'd5,  2'd0, 2'd1, 13'h0003, 3'b100, 1'b1, 1'b1, 2'd1},
    {4'd6,  2'd2, 2'd2, 13'h0400, 3'b010, 1'b1, 1'b0, 2'd2},
    {4'd7,  2'd3, 2'd0, 13'h0000, 3'b010, 1'b1, 1'b0, 2'd1},
    {4'd8,  2'd0, 2'd1, 13'h0ABC, 3'b001, 1'b0, 1'b0, 2'd3},
    {4'd9,  2'd1, 2'd2, 13'h0FFF, 3'b001, 1'b0, 1'b0, 2'd3},
    {4'd10, 2'd2, 2'd0, 13'h0033, 3'b000, 1'b1, 1'b0, 2'd0},
    {4'd15, 2'd3, 2'd1, 13'h1111, 3'b111, 1'b0, 1'b0, 2'd3}
  };

  function automatic logic [14:0] exp_addr(input logic [1:0] b, input logic [12:0] a,
                                           input logic [1:0] rule);
    logic [14:0] v;
    v = {b, a};
    case (rule)
      2'd1: v[10] = 1'b1;
      2'd2: v[10] = 1'b0;
      2'd3: v = '0;
      default: ;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] cs, input logic [1:0] b,
                      input logic [12:0] a, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_cs = cs; cmd_bank = b; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    check(req, {cs_n, ras_n, cas_n, we_n, dq_oe}, {4'hF, 3'b111, 1'b0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_cs = '0; cmd_bank = '0;
    cmd_addr = '0; cmd_wdata = '0; cke_in = 4'h3; dqm_in = 4'h0;
    ctl_gnt = 1'b0; bus_gnt = 1'b0;
    repeat (3) step();

    // R13 reset state
    check("R13 ready/reqs", {cmd_ready, ctl_req, bus_req}, 3'b100);
    check_idle("R13 pins");
    check("R13 addr", addr_o, 15'h0);
    check("R13 cke/dqm", {cke_o, dqm_o}, {4'h0, 4'hF});
    rst = 1'b0;
    step();
    check("R1 group one after reset", {cke_o, dqm_o}, {4'h3, 4'h0});

    // Table walk, both grants high
    ctl_gnt = 1'b1; bus_gnt = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      logic [3:0]  exp_cs;
      v = VEC[i];
      send(v[27:24], v[23:22], v[21:20], v[19:7], 32'hC0DE_0000 | 32'(i));
      check("R2 ready low while pending", cmd_ready, 1'b0);
      check("R3 requests while pending", {ctl_req, bus_req}, {1'b1, v[3]});
      step();
      exp_cs = ~(4'b0001 << v[23:22]);
      check("R9 chip select", cs_n, exp_cs);
      check("R7 strobes", {ras_n, cas_n, we_n}, v[6:4]);
      check("R8 address", addr_o, exp_addr(v[21:20], v[19:7], v[1:0]));
      check("R10 data enable", {dq_oe, dq_o}, {v[2], v[2] ? (32'hC0DE_0000 | 32'(i)) : 32'h0});
      check("R3 requests in issue cycle", {ctl_req, bus_req}, {1'b1, v[3]});
      step();
      check("R11 requests dropped", {ctl_req, bus_req, cmd_ready}, 3'b001);
      check_idle("R6 idle after issue");
      check("R8 address idle", addr_o, 15'h0);
    end

    // R4: addressed command ignores control grant, waits on bus grant
    ctl_gnt = 1'b1; bus_gnt = 1'b0;
    send(4'd4, 2'd2, 2'd1, 13'h0155, 32'hDEAD_BEEF);
    cke_in = 4'hA; dqm_in = 4'h5;
    for (int k = 0; k < 3; k++) begin
      step();
      check_idle("R4 stall with ctl_gnt only");
      check("R4 waiting reqs", {cmd_ready, ctl_req, bus_req}, 3'b011);
    end
    check("R1 group one during stall", {cke_o, dqm_o}, {4'hA, 4'h5});
    check("R1 memory clock", mem_clk_o, 1'b0);
    ctl_gnt = 1'b0; bus_gnt = 1'b1;
    step();
    check("R4 issue on bus_gnt alone", {cs_n, ras_n, cas_n, we_n, dq_oe}, {4'hB, 3'b100, 1'b1});
    check("R10 write data", dq_o, 32'hDEAD_BEEF);
    check("R8 write address", addr_o, 15'h2155);
    step();

    // R5: address-less command ignores bus grant
    ctl_gnt = 1'b0; bus_gnt = 1'b1;
    send(4'd8, 2'd3, 2'd0, 13'h0000, 32'h0);
    for (int k = 0; k < 3; k++) begin
      step();
      check_idle("R5 stall with bus_gnt only");
      check("R5 waiting reqs", {ctl_req, bus_req}, 2'b10);
    end
    ctl_gnt = 1'b1; bus_gnt = 1'b0;
    step();
    check("R5 issue on ctl_gnt", {cs_n, ras_n, cas_n, we_n}, {4'h7, 3'b001});
    step();

    // R12: undefined code waits on control grant, no bus request
    ctl_gnt = 1'b0; bus_gnt = 1'b1;
    send(4'd12, 2'd0, 2'd2, 13'h0777, 32'h1);
    step();
    check("R12 no bus request, stalled", {bus_req, cs_n}, {1'b0, 4'hF});
    ctl_gnt = 1'b1;
    step();
    check("R12 issued as no-op", {cs_n, ras_n, cas_n, we_n, addr_o}, {4'hE, 3'b111, 15'h0});
    step();

    // R11: back-to-back keeps the request up
    ctl_gnt = 1'b1; bus_gnt = 1'b1;
    send(4'd1, 2'd1, 2'd0, 13'h0042, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R11 first command on pins", {cs_n, ras_n}, {4'hD, 1'b0});
    send(4'd2, 2'd1, 2'd0, 13'h0008, 32'h0);
    check("R11 request held between commands", {ctl_req, bus_req}, 2'b11);
    check_idle("R6 gap cycle");
    step();
    check("R11 second command issued", {cs_n, ras_n, cas_n, we_n}, {4'hD, 3'b101});
    step();
    check("R11 requests finally dropped", {ctl_req, bus_req}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule